// File: doc/BRIEF.md
# Byte-wide configuration write port

This block is the slave side of an 8-bit parallel configuration port. It is clocked by the configuration clock. A host selects the port with an active-low chip select and chooses the transfer direction with an active-low write strobe. On every rising edge where the port is selected and set to write, the block takes one byte from the data pins. It then offers that byte downstream on a valid/ready stream, in the order the bytes arrived.

A registered busy output tells the host to hold the current byte and present it again. A small skid buffer lets busy be registered without losing a byte. The block does not look at packet boundaries. A stream of bytes keeps its order when the host releases chip select and selects the port again later, so one packet may span several selections.

The write strobe may not change direction while chip select stays low across consecutive edges. If it does, the block raises an abort. It empties the skid buffer and holds busy high for a fixed number of cycles. Once configuration is marked complete, the port ignores chip select entirely, unless a retain input keeps it in service.

Top module: `cfg_byte_port`

## Requirements
- R1: The byte on `din` is captured on a rising edge when all of these hold: the port is enabled, `cs_n`=0, `wr_n`=0, `busy`=0, and no abort is detected on that edge. After that edge, `out_valid` is 1 with the byte on `out_data` (when the buffer was empty before).
- R2: Bytes leave on `out_data` in the order they were captured, including across edges where `cs_n` is 1 between two captures.
- R3: An edge with `cs_n`=0 and `wr_n`=1 captures nothing and raises no abort.
- R4: `busy` is a registered output. It is 1 whenever the skid buffer holds DEPTH bytes (default 2). On an edge where `busy` is 1, the byte on `din` is not captured.
- R5: An abort is two consecutive rising edges where the port is enabled and `cs_n`=0 on both, with different `wr_n` levels. After the second edge, `abort_pulse` is 1 for that one cycle. `out_valid` is 0 because the buffer has been emptied, and nothing is captured on that edge.
- R6: After an abort edge, `busy` is 1 for exactly HOLD_CYCLES cycles (default 4), unless the buffer is full. It is 0 in the cycle after that.
- R7: With `cfg_done`=1 and `retain`=0, `cs_n` is ignored: nothing is captured and no abort is raised.
- R8: With `cfg_done`=1 and `retain`=1, the port captures bytes as in R1.
- R9: During and right after reset, `out_valid`, `busy` and `abort_pulse` are 0.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged until the next abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (1 means read direction) |
| din | input | 8 | Data byte from the host |
| cfg_done | input | 1 | Configuration complete flag |
| retain | input | 1 | Keeps the port in service after configuration |
| busy | output | 1 | Host must hold and present the byte again |
| out_valid | output | 1 | Downstream byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Downstream byte |
| abort_pulse | output | 1 | One-cycle abort indication |

## Verification
Most internal faults show up at the ports in the cycle after the edge that caused them:
- A wrong buffer pointer or count shows as a byte out of order, a repeated byte or a missing byte on `out_data`. It can also leave `busy` wrong for the next host write.
- A stale direction sample in the abort detector either misses an abort or raises a false one at the next selected edge.
- A wrong hold counter moves the edge where `busy` falls by a cycle or more after an abort.

The bench compares every port after every edge against an arithmetic model. It runs a sweep over all pairs of consecutive input combinations, so each fault appears within one or two edges of its cause.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned CFG_BYTE_W = 8;

  typedef logic [CFG_BYTE_W-1:0] cfg_byte_t;

  // Sample of the host bus taken on the previous edge.
  typedef struct packed {
    logic sel;
    logic wr_n;
  } cfg_bus_smp_t;
endpackage

// File: rtl/cfg_port_abort_det.sv
module cfg_port_abort_det
  import cfg_port_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wr_n,
  output logic abort_now,
  output logic abort_pulse,
  output logic hold_busy_next
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  cfg_bus_smp_t   prev_q, prev_d;
  logic [HW-1:0]  hold_q, hold_d;
  logic           pulse_q, pulse_d;

  always_comb begin
    abort_now = sel && prev_q.sel && (wr_n != prev_q.wr_n);
    prev_d.sel  = sel;
    prev_d.wr_n = wr_n;
    pulse_d = abort_now;
    if (abort_now) begin
      hold_d = HW'(HOLD_CYCLES);
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else begin
      hold_d = '0;
    end
    hold_busy_next = (hold_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q.sel  <= 1'b0;
      prev_q.wr_n <= 1'b1;
      hold_q      <= '0;
      pulse_q     <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      hold_q  <= hold_d;
      pulse_q <= pulse_d;
    end
  end

  assign abort_pulse = pulse_q;

  // R6: the hold window starts full after every abort
  a_r6_hold_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (hold_q == HW'(HOLD_CYCLES)));

  // R6: the hold window counts down by one per cycle
  a_r6_hold_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) && !abort_now |=> (hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/cfg_port_skid.sv
module cfg_port_skid #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         full_next
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_push = push && !flush;
    do_pop  = pop && !flush && (cnt_q != '0);
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_adv(wr_q);
      if (do_pop)  rd_d = ptr_adv(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
    full_next = (cnt_d == CW'(DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic we;
    assign we = do_push && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (we) mem_q[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign valid = (cnt_q != '0);
  assign dout  = mem_q[rd_q];

  // R4: the buffer never receives a byte while full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));

  // R4: occupancy stays within the buffer
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R10: a stalled head byte holds still
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !pop && !flush |=> valid && $stable(dout));
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic [CFG_BYTE_W-1:0] din,
  input  logic                  cfg_done,
  input  logic                  retain,
  output logic                  busy,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CFG_BYTE_W-1:0] out_data,
  output logic                  abort_pulse
);
  logic port_en, sel, push, pop;
  logic abort_now, hold_busy_next, full_next;
  logic busy_q, busy_d;

  always_comb begin
    port_en = !cfg_done || retain;
    sel     = port_en && !cs_n;
    push    = sel && !wr_n && !busy_q && !abort_now;
    pop     = out_valid && out_ready;
    busy_d  = hold_busy_next || full_next;
  end

  cfg_port_abort_det #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_abort (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .wr_n          (wr_n),
    .abort_now     (abort_now),
    .abort_pulse   (abort_pulse),
    .hold_busy_next(hold_busy_next)
  );

  cfg_port_skid #(
    .DEPTH(DEPTH),
    .W    (CFG_BYTE_W)
  ) u_skid (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .din      (din),
    .pop      (pop),
    .flush    (abort_now),
    .valid    (out_valid),
    .dout     (out_data),
    .full_next(full_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R1: a captured byte is offered downstream after the edge
  a_r1_capture_offered: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> out_valid);

  // R5: an abort leaves the buffer empty and the host held off
  a_r5_abort_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!out_valid && busy));

  // R7: a disabled port never reports an abort
  a_r7_off_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !retain) |=> !abort_pulse);
endmodule

// File: tb/cfg_byte_port_tb_top.sv
module cfg_byte_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, cfg_done, retain, out_ready;
  logic [7:0] din;
  logic       busy, out_valid, abort_pulse;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  cfg_byte_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .cfg_done(cfg_done), .retain(retain), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .abort_pulse(abort_pulse)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Model state, DEPTH=2, hold of 4
  logic [7:0] mq [2];
  int   qn = 0;
  int   m_hold = 0;
  bit   m_busy = 0, m_abort = 0, psel = 0, pwr = 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
  task automatic step(input bit cs, input bit wr, input logic [7:0] d,
                      input bit rdy, input bit done, input bit ret);
    bit sel, ab, pop, push;
    cs_n = cs; wr_n = wr; din = d; out_ready = rdy; cfg_done = done; retain = ret;
    @(posedge clk);
    sel  = !cs && (!done || ret);
    ab   = sel && psel && (wr != pwr);
    pop  = (qn > 0) && rdy;
    push = sel && !wr && !m_busy && !ab;
    if (ab) qn = 0;
    else begin
      if (pop) begin mq[0] = mq[1]; qn--; end
      if (push) begin mq[qn] = d; qn++; end
    end
    m_hold  = ab ? 4 : (m_hold > 0 ? m_hold - 1 : 0);
    m_busy  = (m_hold != 0) || (qn == 2);
    m_abort = ab;
    psel = sel; pwr = wr;
    @(negedge clk);
    chk("R1", "out_valid", int'(out_valid), int'(qn > 0));
    if (qn > 0) chk("R2", "out_data", int'(out_data), int'(mq[0]));
    chk("R4", "busy", int'(busy), int'(m_busy));
    chk("R5", "abort_pulse", int'(abort_pulse), int'(m_abort));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1; wr_n = 1; din = 0; cfg_done = 0; retain = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    chk("R9", "reset out_valid", int'(out_valid), 0);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset abort_pulse", int'(abort_pulse), 0);
    rst_n = 1'b1;
    step(1, 1, 8'h00, 0, 0, 0);
    chk("R9", "idle out_valid", int'(out_valid), 0);

    // R1 basic capture
    step(0, 0, 8'hA5, 0, 0, 0);
    chk("R1", "captured valid", int'(out_valid), 1);
    chk("R1", "captured data", int'(out_data), 8'hA5);
    // R10 stall hold
    step(1, 1, 8'h00, 0, 0, 0);
    step(1, 1, 8'h00, 0, 0, 0);
    chk("R10", "stalled data", int'(out_data), 8'hA5);
    // R4 fill, then byte offered while busy is dropped
    step(0, 0, 8'h3C, 0, 0, 0);
    chk("R4", "busy when full", int'(busy), 1);
    step(0, 0, 8'h77, 0, 0, 0);
    step(1, 1, 8'h00, 1, 0, 0);
    chk("R2", "second byte", int'(out_data), 8'h3C);
    step(1, 1, 8'h00, 1, 0, 0);
    chk("R4", "busy byte dropped", int'(out_valid), 0);
    // R2 across a select gap
    step(0, 0, 8'h11, 0, 0, 0);
    step(1, 1, 8'h00, 0, 0, 0);
    step(0, 0, 8'h22, 0, 0, 0);
    step(1, 1, 8'h00, 1, 0, 0);
    chk("R2", "gap order", int'(out_data), 8'h22);
    step(1, 1, 8'h00, 1, 0, 0);
    // R3 read direction ignored
    step(0, 1, 8'h99, 1, 0, 0);
    chk("R3", "read no capture", int'(out_valid), 0);
    chk("R3", "read no abort", int'(abort_pulse), 0);
    step(1, 1, 8'h00, 0, 0, 0);
    // R5 abort and R6 hold
    step(0, 0, 8'h44, 0, 0, 0);
    step(0, 1, 8'h55, 0, 0, 0);
    chk("R5", "abort pulse", int'(abort_pulse), 1);
    chk("R5", "abort flush", int'(out_valid), 0);
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 8'h00, 0, 0, 0);
      chk("R6", "hold busy", int'(busy), 1);
    end
    step(1, 1, 8'h00, 0, 0, 0);
    chk("R6", "hold ends", int'(busy), 0);
    chk("R5", "single pulse", int'(abort_pulse), 0);
    // R7 port switched off
    step(0, 0, 8'h66, 0, 1, 0);
    chk("R7", "off no capture", int'(out_valid), 0);
    step(0, 1, 8'h67, 0, 1, 0);
    step(0, 0, 8'h68, 0, 1, 0);
    chk("R7", "off no abort", int'(abort_pulse), 0);
    chk("R7", "off still empty", int'(out_valid), 0);
    // R8 retained port
    step(1, 1, 8'h00, 0, 1, 1);
    step(0, 0, 8'h88, 0, 1, 1);
    chk("R8", "retain capture", int'(out_data), 8'h88);
    step(1, 1, 8'h00, 1, 1, 1);

    // Sweep all pairs of consecutive input combinations
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        step(a[0], a[1], 8'(a * 32 + b), a[2], a[3], a[4]);
        step(b[0], b[1], 8'(b * 7 + a + 1), b[2], b[3], b[4]);
      end
    end

    summary();
    $finish;
  end
endmodule